// File: doc/BRIEF.md
# I2C Target Register Bank

This block is an I2C target that answers one fixed 7-bit address and holds twenty-one byte-wide registers at sub-addresses 0x00 to 0x14. SCL and SDA come in from open-drain pads. Each line passes through a two-flop synchronizer, and all edge detection runs in the system clock domain. The system clock must be at least eight times the SCL rate, so standard mode (100 kbit/s) and fast mode (400 kbit/s) are both covered at ordinary clock rates. The block drives SDA only through an active-high pull-down enable. It never drives a strong high.

A controller writes by sending the address with the write bit, then a sub-address byte, then any number of data bytes. The pointer steps up by one after each data byte. A controller reads by setting the pointer the same way, issuing a repeated START, and sending the address with the read bit. The target then returns bytes from the pointer, steps the pointer after each byte, and stops driving once the controller answers a byte with NACK. Sub-addresses above 0x14 are still ACKed on write, but the data is dropped. On read they return 0xFF.

A parallel local port sits beside the bus. Local logic can load a register with a one-cycle write strobe, and it can read any register combinationally.

Top module: `i2c_target_regs`

## Requirements
- R1: After reset, `sda_oe` is 0 and every register reads 0x00 on `loc_rdata`.
- R2: A byte whose upper seven bits equal 0x6B is ACKed: SDA is held low through the ninth SCL pulse. The lowest bit selects read (1) or write (0).
- R3: A byte with any other address is NACKed. The target then leaves SDA released and changes no register until the next START or STOP.
- R4: In a write, the first byte after the address is the pointer, and each following data byte goes to the register the pointer names. The pointer then steps by one, and every byte is ACKed.
- R5: Data bytes written at sub-addresses above 0x14 are ACKed but change no register. In particular, they do not wrap onto 0x00.
- R6: After a repeated START with the read bit set, the target sends the byte at the pointer, MSB first, and steps the pointer after each byte.
- R7: A read at any sub-address above 0x14 returns 0xFF.
- R8: When the controller answers a read byte with NACK, the target releases SDA and drives nothing more until the next START.
- R9: A STOP in the middle of a byte ends the transaction and writes nothing. A START in the middle of a byte restarts address reception.
- R10: A pulse on `loc_we` writes `loc_wdata` into register `loc_addr`. `loc_rdata` always shows register `loc_addr`, and bus reads see values loaded locally.
- R11: `sda_oe` changes only while the synchronized SCL is low. It is therefore stable during every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 5 | Local register index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Register contents at `loc_addr` (0xFF when out of range) |

## Verification
The hardest state to reach from the ports is a transaction cut off partway through a byte. The bench builds this from single SCL pulses: it clocks four bits of a data byte and then issues STOP, and in a second case it clocks three bits and issues a fresh START. Register contents are then checked over the local port. Each pulse happens while the bench is also modelling the wired-AND bus, so the target's own pull-down competes with the controller on every ACK and read bit. SCL high phases are sampled at both ends to catch any change in the target's drive.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_RX,
    ST_ACK_W,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } tgt_state_t;

  // True when a sub-address names an existing register.
  function automatic logic reg_in_range(input logic [7:0] a, input int unsigned n);
    return (32'(a) < n);
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_lvl  = scl_ff[1];
  assign sda_lvl  = sda_ff[1];
  assign ev_start = scl_q & scl_lvl & sda_q & ~sda_lvl;
  assign ev_stop  = scl_q & scl_lvl & ~sda_q & sda_lvl;
  assign ev_rise  = scl_lvl & ~scl_q;
  assign ev_fall  = ~scl_lvl & scl_q;

endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile
  import i2c_tgt_pkg::*;
#(
  parameter int NREGS = 21,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  logic [NREGS-1:0][DW-1:0] mem;
  logic bus_ok, loc_ok;

  assign bus_ok = reg_in_range(bus_addr, NREGS);
  assign loc_ok = reg_in_range(8'(loc_addr), NREGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      if (loc_we && loc_ok) mem[loc_addr] <= loc_wdata;
      if (bus_we && bus_ok) mem[bus_addr[AW-1:0]] <= bus_wdata;
    end
  end

  assign bus_rdata = bus_ok ? mem[bus_addr[AW-1:0]] : '1;
  assign loc_rdata = loc_ok ? mem[loc_addr] : '1;

  p_oor_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_ok && !loc_we) |=> $stable(mem));

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h6B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic [7:0] bus_rdata,
  output logic       bus_we,
  output logic [7:0] bus_addr,
  output logic [7:0] bus_wdata,
  output logic       sda_oe
);
  tgt_state_t st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr;
  logic       rw, first, nack;
  logic       byte_done, addr_hit;

  assign byte_done = ev_fall && (cnt == 4'd8);
  assign addr_hit  = (sh[7:1] == TGT_ADDR);
  assign bus_we    = byte_done && (st == ST_RX) && !first;
  assign bus_addr  = ptr;
  assign bus_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; first <= 1'b0; nack <= 1'b0; sda_oe <= 1'b0;
    end else if (ev_start) begin
      st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (ev_stop) begin
      st <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_RX: begin
          if (ev_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_lvl};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                sda_oe <= 1'b1; rw <= sh[0]; first <= 1'b1; st <= ST_ACK_A;
              end else begin
                st <= ST_IGNORE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_ACK_W;
              ptr    <= first ? sh : ptr + 8'd1;
            end
          end
        end
        ST_ACK_A: if (ev_fall) begin
          if (rw) begin
            tx <= bus_rdata; sda_oe <= ~bus_rdata[7]; st <= ST_TX;
          end else begin
            sda_oe <= 1'b0; st <= ST_RX;
          end
        end
        ST_ACK_W: if (ev_fall) begin
          sda_oe <= 1'b0; first <= 1'b0; st <= ST_RX;
        end
        ST_TX: begin
          if (ev_rise) begin
            cnt <= cnt + 4'd1;
          end else if (ev_fall && cnt != 4'd0) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0; ptr <= ptr + 8'd1; cnt <= '0; st <= ST_RACK;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (ev_rise) begin
            nack <= sda_lvl;
          end else if (ev_fall) begin
            if (!nack) begin
              tx <= bus_rdata; sda_oe <= ~bus_rdata[7]; st <= ST_TX;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);

  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && ev_fall && nack && !ev_start && !ev_stop) |=> (st == ST_IGNORE && !sda_oe));

  p_stop_mid_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (st == ST_IDLE && !sda_oe && !bus_we));

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_lvl);

endmodule

// File: rtl/i2c_target_regs.sv
module i2c_target_regs #(
  parameter logic [6:0] TGT_ADDR = 7'h6B,
  parameter int NREGS = 21,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [7:0]    loc_wdata,
  output logic [7:0]    loc_rdata
);
  logic scl_lvl, sda_lvl, ev_start, ev_stop, ev_rise, ev_fall;
  logic bus_we;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;

  i2c_tgt_sync u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_lvl, .sda_lvl, .ev_start, .ev_stop, .ev_rise, .ev_fall
  );

  i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
    .clk, .rst_n, .scl_lvl, .sda_lvl, .ev_start, .ev_stop, .ev_rise, .ev_fall,
    .bus_rdata, .bus_we, .bus_addr, .bus_wdata, .sda_oe
  );

  i2c_tgt_regfile #(.NREGS(NREGS), .DW(8)) u_regs (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .loc_we, .loc_addr, .loc_wdata, .loc_rdata
  );

endmodule

// File: tb/sim_i2c_target_regs.sv
module sim_i2c_target_regs;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [7:0] AW_BYTE = 8'hD6;
  localparam logic [7:0] AR_BYTE = 8'hD7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic loc_we = 1'b0;
  logic [4:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0, loc_rdata;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_target_regs u0 (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_bus), .sda_oe,
    .loc_we, .loc_addr, .loc_wdata, .loc_rdata
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b, output logic steady);
    logic s0, s1;
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
    tick(1); s0 = sda_bus; tick(Q); b = sda_bus; tick(Q-1); s1 = sda_bus;
    scl_m = 1'b0;
    steady = (s0 == b) && (s1 == b);
  endtask

  task automatic do_start();
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a, st;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a, st);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic v, st;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v, st);
      b[i] = v;
      chk("R11 sda steady in high phase", int'(st), 1);
    end
    bit_out(ack ? 1'b0 : 1'b1);
  endtask

  task automatic read_loc(input int a, output logic [7:0] v);
    loc_addr = 5'(a); tick(1); v = loc_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] v;
    tick(5); rst_n = 1'b1; tick(3);

    // R1 reset state
    chk("R1 sda_oe", int'(sda_oe), 0);
    for (int a = 0; a < 21; a += 5) begin read_loc(a, v); chk("R1 reg", v, 0); end

    // R4 / R5 burst write from 0 through 23
    do_start();
    send_byte(AW_BYTE, ak); chk("R2 address ack", int'(ak), 1);
    send_byte(8'h00, ak);   chk("R4 pointer ack", int'(ak), 1);
    for (int a = 0; a < 24; a++) begin
      send_byte(pat(a), ak);
      if (a < 21) chk("R4 data ack", int'(ak), 1);
      else        chk("R5 oor data ack", int'(ak), 1);
    end
    do_stop(); tick(4);
    for (int a = 0; a < 21; a++) begin read_loc(a, v); chk("R4 stored", v, pat(a)); end
    for (int a = 0; a < 3; a++) begin read_loc(a, v); chk("R5 no wrap", v, pat(a)); end

    // R6 / R7 / R8 burst read through repeated START
    do_start(); send_byte(AW_BYTE, ak); send_byte(8'h00, ak);
    do_start(); send_byte(AR_BYTE, ak); chk("R6 read address ack", int'(ak), 1);
    for (int a = 0; a < 24; a++) begin
      recv_byte(a != 23, v);
      if (a < 21) chk("R6 read data", v, pat(a));
      else        chk("R7 oor read", v, 8'hFF);
    end
    tick(2); chk("R8 released after nack", int'(sda_oe), 0);
    begin logic b, st; bit_in(b, st); chk("R8 silent after nack", int'(b), 1); end
    do_stop();

    // R7 read starting well above range
    do_start(); send_byte(AW_BYTE, ak); send_byte(8'h40, ak);
    do_start(); send_byte(AR_BYTE, ak); recv_byte(1'b0, v);
    chk("R7 read at 0x40", v, 8'hFF); do_stop();

    // R10 local port
    loc_addr = 5'd7; loc_wdata = 8'hA5; loc_we = 1'b1; tick(1); loc_we = 1'b0;
    read_loc(7, v); chk("R10 local write", v, 8'hA5);
    do_start(); send_byte(AW_BYTE, ak); send_byte(8'h07, ak);
    do_start(); send_byte(AR_BYTE, ak); recv_byte(1'b0, v);
    chk("R10 bus sees local value", v, 8'hA5); do_stop();

    // R3 address mismatches
    for (int k = 0; k < 5; k++) begin
      logic [6:0] wa;
      case (k)
        0: wa = 7'h6A;
        1: wa = 7'h6C;
        2: wa = 7'h4B;
        3: wa = 7'h2B;
        default: wa = 7'h7B;
      endcase
      do_start();
      send_byte({wa, 1'b0}, ak); chk("R3 mismatch nack", int'(ak), 0);
      send_byte(8'h05, ak);      chk("R3 ignored byte", int'(ak), 0);
      send_byte(8'h77, ak);      chk("R3 ignored byte", int'(ak), 0);
      do_stop(); tick(2);
      read_loc(5, v); chk("R3 reg untouched", v, pat(5));
    end

    // R9 STOP mid-byte
    do_start(); send_byte(AW_BYTE, ak); send_byte(8'h03, ak);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    do_stop(); tick(2);
    read_loc(3, v); chk("R9 stop aborts byte", v, pat(3));

    // R9 START mid-byte
    do_start(); send_byte(AW_BYTE, ak); send_byte(8'h04, ak);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    do_start();
    send_byte(AW_BYTE, ak); chk("R9 restart address ack", int'(ak), 1);
    send_byte(8'h04, ak); send_byte(8'h3C, ak);
    do_stop(); tick(2);
    read_loc(4, v); chk("R9 write after restart", v, 8'h3C);
    read_loc(5, v); chk("R9 neighbour intact", v, pat(5));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule